// File: doc/BRIEF.md
# Line-Buffered Upstream Read Initiator

This block answers memory reads that arrive from a downstream bus and are meant for an upstream, PCI-style bus. It keeps four line buffers, each holding one 16-byte line as four 32-bit words together with a tag and a valid bit. A read that finds its line in a valid buffer is answered from that buffer with no upstream traffic. A read that misses, or that arrives while every buffer is empty, makes the block act as upstream bus initiator. It issues one linear incrementing burst that fetches the whole aligned line into a buffer, and it returns the requested word once the last beat of the line has arrived.

Reads marked bypass, and all reads while line buffering is switched off, go upstream as a single word transfer and leave the buffers untouched. If no upstream target claims the cycle by asserting the device-select input within the timeout, the block ends the cycle as a master abort and answers with all ones. A flush input drops every buffered line in one clock.

Requests and responses are valid/ready streams. `req_ready` is high only while the block is idle and holds no unread response, so a request is taken on any clock edge where `req_valid` and `req_ready` are both high. After `rsp_valid` rises, the response stays valid and its data stays unchanged until a clock edge where `rsp_ready` is high.

Top module: `rdline_fetch`

## Requirements
- R1: With buffering enabled and bypass low, a read whose 16-byte line is held in a valid buffer returns the stored word with no upstream address phase.
- R2: A buffered read that misses issues one upstream burst (`up_burst`=1) of four beats for its line, stores the four words in ascending address order, and raises `rsp_valid` only after the fourth beat, carrying the word at `req_addr[3:2]`.
- R3: Every upstream address phase drives `up_addr[1:0]`=00, which selects linear incrementing order. A burst address is line aligned (`up_addr[3:0]`=0). An address phase lasts exactly one clock.
- R4: When `buf_en` is low or `req_bypass` is high, the read is one single transfer (`up_burst`=0) at the word-aligned request address, and no buffer is filled.
- R5: The buffer refilled on a miss is chosen round-robin: buffers 0, 1, 2, 3, 0, … in the order of the misses, whatever the hit history.
- R6: A one-clock pulse on `flush` invalidates all buffers. A fill that overlaps `flush` in any cycle, including the cycle of its last beat, leaves its line invalid.
- R7: If `up_devsel` is not seen in any of the first TMO clocks after the address phase, the read ends with `rsp_data`=FFFFFFFFh and no line becomes valid. `up_devsel` in clock TMO is still accepted.
- R8: `req_ready` is high only in idle with no pending response. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold.
- R9: After reset, `req_ready`=1, `rsp_valid`=0, `up_start`=0 and all buffers are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_en | input | 1 | Line buffering enable |
| flush | input | 1 | Invalidate all line buffers |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted when high with req_valid |
| req_addr | input | 32 | Byte address of the read |
| req_bypass | input | 1 | Serve this read as a single upstream transfer |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Downstream takes the read data |
| rsp_data | output | 32 | Read data, FFFFFFFFh after a master abort |
| up_start | output | 1 | Upstream address phase, one clock |
| up_addr | output | 32 | Upstream address, low two bits 00 |
| up_burst | output | 1 | 1: four-beat line burst, 0: single transfer |
| up_devsel | input | 1 | Target claims the upstream cycle |
| up_dvalid | input | 1 | Upstream data beat present |
| up_data | input | 32 | Upstream data |

## Verification
Flush and fill completion can land in the same clock, where a flush would clear valid bits just as the finishing fill sets one. The bench holds `flush` high for the whole of a fill, so it covers the last-beat cycle, and then re-reads the line. A second upstream address phase proves that the line stayed invalid. The timeout counter and a late device-select also meet at the boundary. A claim in clock TMO must return real data, and a claim in clock TMO+1 must come too late and give all ones.

// File: rtl/rdl_pkg.sv
package rdl_pkg;
  typedef enum logic [1:0] {T_IDLE, T_BUSY, T_RESP} top_st_t;
  typedef enum logic [1:0] {M_IDLE, M_ADDR, M_WAIT} mst_st_t;
endpackage

// File: rtl/rdl_tags.sv
module rdl_tags #(
  parameter int LINES = 4,
  parameter int TAG_W = 28,
  localparam int LI = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [LI-1:0]    hit_idx,
  output logic [LI-1:0]    victim,
  input  logic             alloc,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             set_vld,
  input  logic [LI-1:0]    set_idx,
  input  logic             flush
);
  logic [LINES-1:0] vld;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] match;

  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    assign match[i] = vld[i] && (tag_q[i] == lk_tag);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match[i]) hit_idx = LI'(i);
    end
  end
  assign hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      victim <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else begin
      if (alloc) begin
        vld[victim]   <= 1'b0;
        tag_q[victim] <= alloc_tag;
        victim        <= (victim == LI'(LINES - 1)) ? '0 : victim + 1'b1;
      end
      if (set_vld) vld[set_idx] <= 1'b1;
      if (flush) vld <= '0;
    end
  end
endmodule

// File: rtl/rdl_data.sv
module rdl_data #(
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int LI = $clog2(LINES),
  localparam int WI = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LI-1:0]     wr_line,
  input  logic [WI-1:0]     wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LI-1:0]     rd_line,
  input  logic [WI-1:0]     rd_word,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [LINES*WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_line, wr_word}] <= wr_data;
  end

  assign rd_data = mem[{rd_line, rd_word}];
endmodule

// File: rtl/rdl_master.sv
module rdl_master
  import rdl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int TMO    = 5,
  localparam int WI = $clog2(WORDS),
  localparam int CW = $clog2(TMO) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic              go_burst,
  output logic              up_start,
  output logic [ADDR_W-1:0] up_addr,
  output logic              up_burst,
  input  logic              up_devsel,
  input  logic              up_dvalid,
  input  logic [DATA_W-1:0] up_data,
  output logic              beat,
  output logic [WI-1:0]     beat_idx,
  output logic [DATA_W-1:0] beat_data,
  output logic              done,
  output logic              abort
);
  mst_st_t       st;
  logic [CW-1:0] cnt;
  logic          seen;
  logic          seen_now;
  logic [WI-1:0] last_idx;

  assign seen_now  = seen || up_devsel;
  assign last_idx  = up_burst ? WI'(WORDS - 1) : '0;
  assign beat      = (st == M_WAIT) && seen_now && up_dvalid;
  assign beat_data = up_data;
  assign done      = beat && (beat_idx == last_idx);
  assign abort     = (st == M_WAIT) && !seen_now && (cnt == CW'(TMO - 1));
  assign up_start  = (st == M_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= M_IDLE;
      cnt      <= '0;
      seen     <= 1'b0;
      beat_idx <= '0;
      up_addr  <= '0;
      up_burst <= 1'b0;
    end else begin
      case (st)
        M_IDLE: if (go) begin
          up_addr  <= go_addr;
          up_burst <= go_burst;
          st       <= M_ADDR;
        end
        M_ADDR: begin
          cnt      <= '0;
          seen     <= 1'b0;
          beat_idx <= '0;
          st       <= M_WAIT;
        end
        M_WAIT: begin
          seen <= seen_now;
          if (beat) beat_idx <= beat_idx + 1'b1;
          if (done || abort) st <= M_IDLE;
          else if (!seen_now) cnt <= cnt + 1'b1;
        end
        default: st <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdline_fetch.sv
module rdline_fetch
  import rdl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int TMO    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_en,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_bypass,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              up_start,
  output logic [ADDR_W-1:0] up_addr,
  output logic              up_burst,
  input  logic              up_devsel,
  input  logic              up_dvalid,
  input  logic [DATA_W-1:0] up_data
);
  localparam int LI    = $clog2(LINES);
  localparam int WI    = $clog2(WORDS);
  localparam int BO    = $clog2(DATA_W / 8);
  localparam int OFF   = WI + BO;
  localparam int TAG_W = ADDR_W - OFF;

  top_st_t           st;
  logic [WI-1:0]     woff_q;
  logic              fill_q;
  logic [LI-1:0]     slot_q;
  logic              stale_q;

  logic              hit;
  logic [LI-1:0]     hit_idx;
  logic [LI-1:0]     victim;
  logic [DATA_W-1:0] rd_data;
  logic              beat, done, abort;
  logic [WI-1:0]     beat_idx;
  logic [DATA_W-1:0] beat_data;

  logic              accept, use_buf, take_hit, go, set_vld;
  logic [WI-1:0]     req_word;
  logic [TAG_W-1:0]  req_tag;
  logic [ADDR_W-1:0] go_addr;

  assign req_ready = (st == T_IDLE);
  assign rsp_valid = (st == T_RESP);
  assign accept    = req_ready && req_valid;
  assign use_buf   = buf_en && !req_bypass;
  assign take_hit  = accept && use_buf && hit;
  assign go        = accept && !take_hit;
  assign req_word  = req_addr[OFF-1:BO];
  assign req_tag   = req_addr[ADDR_W-1:OFF];
  assign go_addr   = use_buf ? {req_tag, {OFF{1'b0}}}
                             : {req_addr[ADDR_W-1:BO], {BO{1'b0}}};
  assign set_vld   = done && fill_q && !stale_q && !flush;

  rdl_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .lk_tag(req_tag), .hit(hit), .hit_idx(hit_idx),
    .victim(victim), .alloc(go && use_buf), .alloc_tag(req_tag),
    .set_vld(set_vld), .set_idx(slot_q), .flush(flush)
  );

  rdl_data #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .wr_en(beat && fill_q), .wr_line(slot_q), .wr_word(beat_idx),
    .wr_data(beat_data), .rd_line(hit_idx), .rd_word(req_word), .rd_data(rd_data)
  );

  rdl_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .TMO(TMO)) u_mst (
    .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr), .go_burst(use_buf),
    .up_start(up_start), .up_addr(up_addr), .up_burst(up_burst),
    .up_devsel(up_devsel), .up_dvalid(up_dvalid), .up_data(up_data),
    .beat(beat), .beat_idx(beat_idx), .beat_data(beat_data),
    .done(done), .abort(abort)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= T_IDLE;
      rsp_data <= '0;
      woff_q   <= '0;
      fill_q   <= 1'b0;
      slot_q   <= '0;
      stale_q  <= 1'b0;
    end else begin
      case (st)
        T_IDLE: begin
          if (take_hit) begin
            rsp_data <= rd_data;
            st       <= T_RESP;
          end else if (go) begin
            woff_q  <= req_word;
            fill_q  <= use_buf;
            slot_q  <= victim;
            stale_q <= 1'b0;
            st      <= T_BUSY;
          end
        end
        T_BUSY: begin
          stale_q <= stale_q || flush;
          if (beat && (!fill_q || beat_idx == woff_q)) rsp_data <= beat_data;
          if (abort) begin
            rsp_data <= '1;
            st       <= T_RESP;
          end else if (done) begin
            st <= T_RESP;
          end
        end
        T_RESP: if (rsp_ready) st <= T_IDLE;
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdline_fetch_chk.sv
module rdline_fetch_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              up_start,
  input logic [ADDR_W-1:0] up_addr,
  input logic              up_burst
);
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_no_accept_while_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_linear_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    up_start |-> up_addr[1:0] == 2'b00);

  assert_line_aligned_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    up_start && up_burst |-> up_addr[3:0] == 4'h0);

  assert_one_clock_addr_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    up_start |=> !up_start);
endmodule

bind rdline_fetch rdline_fetch_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .up_start(up_start),
  .up_addr(up_addr), .up_burst(up_burst)
);

// File: tb/rdline_fetch_test.sv
module rdline_fetch_test;
  localparam int TMO = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        buf_en = 1'b1, flush = 1'b0;
  logic        req_valid = 1'b0, req_bypass = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, up_start, up_burst;
  logic [31:0] rsp_data, up_addr;
  logic        up_devsel = 1'b0, up_dvalid = 1'b0;
  logic [31:0] up_data = '0;

  int tests = 0, fails = 0;
  int nstart = 0;
  logic [31:0] last_addr;
  logic        last_burst;
  int lat = 2;
  bit silent = 1'b0;

  rdline_fetch #(.TMO(TMO)) uut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] mem_of(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // upstream target model
  initial begin
    logic [31:0] a;
    int n, k, w;
    bit act;
    act = 1'b0; a = '0; n = 0; k = 0; w = 0;
    forever begin
      @(negedge clk);
      if (up_dvalid) begin
        k++;
        up_dvalid = 1'b0;
        up_devsel = 1'b0;
        if (k == n) act = 1'b0;
      end
      if (up_start) begin
        nstart++;
        last_addr = up_addr;
        last_burst = up_burst;
        act = 1'b1; a = up_addr; n = up_burst ? 4 : 1; k = 0; w = 0;
      end else if (act) begin
        w++;
        if (w > 40) act = 1'b0;
        else if (!silent && w >= lat) begin
          up_devsel = 1'b1;
          up_dvalid = 1'b1;
          up_data   = mem_of(a + 32'(4 * k));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic do_read(input logic [31:0] addr, input bit byp, input bit en,
                         input logic [31:0] exp_data, input int exp_starts,
                         input string req);
    int s0, cyc;
    s0 = nstart;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    buf_en = en; req_bypass = byp; req_addr = addr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!rsp_valid && cyc < 60) begin @(negedge clk); cyc++; end
    check(req, rsp_data, exp_data);
    check(req, 32'(nstart - s0), 32'(exp_starts));
    repeat (8) @(negedge clk);
  endtask

  // addr, bypass, enable, expect upstream, expect burst
  localparam logic [35:0] VEC [0:13] = '{
    {32'h0000_1000, 1'b0, 1'b1, 1'b1, 1'b1},
    {32'h0000_1008, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'h0000_100C, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'h0000_2004, 1'b0, 1'b1, 1'b1, 1'b1},
    {32'h0000_3000, 1'b0, 1'b1, 1'b1, 1'b1},
    {32'h0000_4000, 1'b0, 1'b1, 1'b1, 1'b1},
    {32'h0000_1004, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'h0000_5000, 1'b0, 1'b1, 1'b1, 1'b1},
    {32'h0000_1000, 1'b0, 1'b1, 1'b1, 1'b1},
    {32'h0000_3008, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'h0000_3004, 1'b1, 1'b1, 1'b1, 1'b0},
    {32'h0000_4000, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_6000, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_6000, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 req_ready", 32'(req_ready), 32'd1);
    check("R9 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R9 up_start", 32'(up_start), 32'd0);

    // R1 hits, R2 fills, R4 single transfers, R5 eviction order (vectors 8 and 9)
    for (int i = 0; i < 14; i++) begin
      logic [31:0] a;
      string tag;
      a = VEC[i][35:4];
      tag = VEC[i][1] ? (VEC[i][0] ? "R2" : "R4") : "R1";
      do_read(a, VEC[i][3], VEC[i][2], mem_of(a), int'(VEC[i][1]), tag);
      if (VEC[i][1]) begin
        check(tag, 32'(last_burst), 32'(VEC[i][0]));
        check("R3", last_addr, VEC[i][0] ? {a[31:4], 4'h0} : {a[31:2], 2'b00});
      end
    end

    // R5: slots now hold 5000->0? no: 0=5000,1=1000,2=6000,3=4000; next victim 3
    do_read(32'h0000_4000, 1'b0, 1'b1, mem_of(32'h4000), 0, "R5 hit before");
    do_read(32'h0000_2000, 1'b0, 1'b1, mem_of(32'h2000), 1, "R5 miss");
    do_read(32'h0000_4004, 1'b0, 1'b1, mem_of(32'h4004), 1, "R5 round-robin evicted");

    // R6 flush pulse
    do_read(32'h0000_2008, 1'b0, 1'b1, mem_of(32'h2008), 0, "R6 hit before flush");
    @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
    do_read(32'h0000_2008, 1'b0, 1'b1, mem_of(32'h2008), 1, "R6 after flush");

    // R6 flush held over a whole fill, including the last-beat cycle
    @(negedge clk); flush = 1'b1;
    do_read(32'h0000_7000, 1'b0, 1'b1, mem_of(32'h7000), 1, "R6 fill under flush");
    flush = 1'b0;
    do_read(32'h0000_7004, 1'b0, 1'b1, mem_of(32'h7004), 1, "R6 line stayed invalid");

    // R7 master abort
    silent = 1'b1;
    do_read(32'h0000_8000, 1'b0, 1'b1, 32'hFFFF_FFFF, 1, "R7 abort");
    silent = 1'b0;
    do_read(32'h0000_8004, 1'b0, 1'b1, mem_of(32'h8004), 1, "R7 no line after abort");
    lat = TMO;
    do_read(32'h0000_9000, 1'b0, 1'b1, mem_of(32'h9000), 1, "R7 devsel at limit");
    lat = TMO + 1;
    do_read(32'h0000_A00C, 1'b0, 1'b1, 32'hFFFF_FFFF, 1, "R7 devsel too late");
    lat = 2;

    // R8 back-pressure on a hit
    rsp_ready = 1'b0;
    @(negedge clk);
    buf_en = 1'b1; req_bypass = 1'b0; req_addr = 32'h0000_900C; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    repeat (3) @(negedge clk);
    check("R8 valid held", 32'(rsp_valid), 32'd1);
    check("R8 data held", rsp_data, held);
    check("R8 data", held, mem_of(32'h900C));
    check("R8 not ready while pending", 32'(req_ready), 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R8 released", 32'(rsp_valid), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule